// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the slave side of a four-wire SPI link (serial clock, active-low select, data in, data out) sitting in front of a byte-addressed nonvolatile store of 2^ADDR_W bytes (4096 by default). A system clock oversamples the link: the four link inputs pass through a synchronizer, and edges of the serial clock are detected in the system clock domain. Mode 0 is used. Data in is taken on a rising serial-clock edge, and data out changes after a falling edge. Every field (instruction, address, data) is most-significant bit first.

Each transaction starts with an 8-bit instruction. Reads and writes then take a 16-bit address. A read streams bytes out through a byte-wide read port whose pointer keeps counting across page boundaries and wraps at the top of the space. A write hands each received byte to a separate commit engine as an address/data strobe. When the select rises, a single commit pulse closes the burst. A write-enable latch gates writes and is dropped after every modification. A hold input freezes a transaction in place without ending it. While the commit engine reports busy, only the status read is accepted.

States: `ST_IDLE` (deselected), `ST_OPC` (instruction bits), `ST_ADDR` (two address bytes), `ST_READ` (data streamed out), `ST_WRITE` (data bytes taken in), `ST_RDSR` (status streamed out), `ST_WRSR` (status byte taken in), `ST_SKIP` (remainder of an ignored or finished command). Transitions:
- `ST_IDLE`→`ST_OPC` when the select falls.
- `ST_OPC`→`ST_ADDR` on a read, or on a write with the latch set.
- `ST_OPC`→`ST_RDSR` on a status read.
- `ST_OPC`→`ST_WRSR` on a status write with the latch set.
- `ST_OPC`→`ST_SKIP` on anything else, or on anything but a status read while busy.
- `ST_ADDR`→`ST_READ` or `ST_WRITE` after the second address byte.
- `ST_WRSR`→`ST_SKIP` after its byte.
- Any state→`ST_IDLE` when the select is high.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, `so_oe` is 0, no write strobe or commit pulse is issued, and the status byte reads 0x00.
- R2: Mode 0, most-significant bit first. `si` is taken on rising `sck` edges, and `so` changes only after falling `sck` edges.
- R3: Instruction 0x03, then a 16-bit address, returns the addressed bytes on `so` for as long as `cs_n` stays low. `so_oe` is 1 only in the data phase.
- R4: The read pointer increments after each byte. It runs across 32-byte page boundaries and wraps from 0xFFF to 0x000.
- R5: Only the low ADDR_W (12) bits of the 16-bit address select a byte. The upper 4 bits have no effect.
- R6: A high `cs_n` returns the block to idle. `so_oe` goes to 0 and any partly received command is dropped.
- R7: While `hold_n` is low, `sck` edges are ignored and `so_oe` is 0. When `hold_n` returns high, the transaction continues where it stopped.
- R8: 0x06 sets the write-enable latch and 0x04 clears it. The status byte (read with 0x05) has bit 0 = commit busy, bit 1 = latch, and bits 7:2 = user bits.
- R9: Instruction 0x02 with the latch set issues one `wr_stb` per data byte, carrying `wr_addr`/`wr_data`. The address wraps within its 32-byte page. Without the latch, the whole command is ignored.
- R10: When `cs_n` rises after a write that delivered at least one byte, `wr_commit` pulses for one cycle and the latch clears.
- R11: Instruction 0x01 with the latch set loads status bits 7:2 from the next byte and clears the latch. Without the latch, it has no effect.
- R12: While `commit_busy` is 1, every instruction except 0x05 is ignored until `cs_n` rises.
- R13: An unknown instruction is ignored until `cs_n` rises: no output is enabled and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transaction freeze |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| rd_addr | output | ADDR_W | Read pointer into the array |
| rd_data | input | 8 | Array byte at `rd_addr` (combinational) |
| wr_stb | output | 1 | One-cycle strobe per received write byte |
| wr_addr | output | ADDR_W | Address for the strobed byte |
| wr_data | output | 8 | Strobed byte |
| wr_commit | output | 1 | One-cycle pulse closing a write burst |
| commit_busy | input | 1 | Commit engine is programming |

## Verification
The hardest case to reach from the ports is a hold that lands in the middle of a data byte, after the pointer has already moved past a page boundary. The bench builds bytes from single-bit steps, so it can drop `hold_n` after an arbitrary bit, toggle `sck` and `si` while the freeze is on, then release it and finish the byte. It then checks that this byte and the next match the bench memory model, and that `so_oe` stayed low during the freeze. The busy window is reached in two ways: by a forced override, and by a real commit whose bench-side busy time is long enough that a status read lands inside it.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_RDSR,
        ST_WRSR,
        ST_SKIP
    } fe_state_e;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    for (genvar g = 0; g < STAGES; g++) begin : g_st
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st[0] <= RST_VAL;
                else        st[0] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st[g] <= RST_VAL;
                else        st[g] <= st[g-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/spi_bit_in.sv
module spi_bit_in #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         rise,
    input  logic         si,
    output logic         byte_done,
    output logic [W-1:0] byte_val
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [W-2:0]     sh;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (rise) begin
            sh  <= {sh[W-3:0], si};
            cnt <= cnt + CNT_ONE;
        end
    end

    assign byte_done = rise && (cnt == CNT_LAST);
    assign byte_val  = {sh, si};
endmodule

// File: rtl/spi_bit_out.sv
module spi_bit_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic         so_bit
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sh <= '0;
        else if (fall) sh <= load ? ld_val : {sh[W-2:0], 1'b0};
    end

    assign so_bit = sh[W-1];
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    input  logic              commit_busy
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);

    logic sck_s, csn_s, si_s, hold_s;
    logic sck_d, csn_d;
    logic rise, fall, cs_end;
    logic byte_done;
    logic [7:0] byte_val;
    logic op_ok;

    fe_state_e state_q, state_d;
    logic              is_read_q, addr_second_q, wel_q;
    logic [HI_W-1:0]   addr_hi_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [5:0]        usr_q;
    logic              need_load_q, out_act_q, wr_any_q;
    logic              wr_stb_q, wr_commit_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [7:0]        wr_data_q;
    logic [7:0]        status_byte, ld_val;

    spi_in_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0101)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sck, cs_n, si, hold_n}),
        .q     ({sck_s, csn_s, si_s, hold_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    assign rise   = sck_s & ~sck_d & hold_s & ~csn_s;
    assign fall   = ~sck_s & sck_d & hold_s & ~csn_s;
    assign cs_end = csn_s & ~csn_d;

    spi_bit_in #(.W(8)) i_bit_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (csn_s),
        .rise      (rise),
        .si        (si_s),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    assign status_byte = {usr_q, wel_q, commit_busy};
    assign ld_val      = (state_q == ST_READ) ? rd_data : status_byte;

    spi_bit_out #(.W(8)) i_bit_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall   (fall),
        .load   (need_load_q),
        .ld_val (ld_val),
        .so_bit (so)
    );

    assign op_ok = !commit_busy || (byte_val == OP_RDSR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!csn_s) state_d = ST_OPC;
            ST_OPC: begin
                if (byte_done) begin
                    if (!op_ok) begin
                        state_d = ST_SKIP;
                    end else begin
                        case (byte_val)
                            OP_READ:  state_d = ST_ADDR;
                            OP_WRITE: state_d = wel_q ? ST_ADDR : ST_SKIP;
                            OP_RDSR:  state_d = ST_RDSR;
                            OP_WRSR:  state_d = wel_q ? ST_WRSR : ST_SKIP;
                            default:  state_d = ST_SKIP;
                        endcase
                    end
                end
            end
            ST_ADDR:  if (byte_done && addr_second_q) state_d = is_read_q ? ST_READ : ST_WRITE;
            ST_WRSR:  if (byte_done) state_d = ST_SKIP;
            ST_READ, ST_WRITE, ST_RDSR, ST_SKIP: state_d = state_q;
        endcase
        if (csn_s) state_d = ST_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_read_q     <= 1'b0;
            addr_second_q <= 1'b0;
            wel_q         <= 1'b0;
            addr_hi_q     <= '0;
            ptr_q         <= '0;
            usr_q         <= '0;
            need_load_q   <= 1'b0;
            out_act_q     <= 1'b0;
            wr_any_q      <= 1'b0;
            wr_stb_q      <= 1'b0;
            wr_commit_q   <= 1'b0;
            wr_addr_q     <= '0;
            wr_data_q     <= '0;
        end else begin
            wr_stb_q    <= 1'b0;
            wr_commit_q <= 1'b0;
            if (csn_s) begin
                need_load_q   <= 1'b0;
                out_act_q     <= 1'b0;
                addr_second_q <= 1'b0;
                wr_any_q      <= 1'b0;
                if (cs_end && state_q == ST_WRITE && wr_any_q) begin
                    wr_commit_q <= 1'b1;
                    wel_q       <= 1'b0;
                end
            end else begin
                unique case (state_q)
                    ST_OPC: begin
                        if (byte_done && op_ok) begin
                            case (byte_val)
                                OP_WREN:  wel_q       <= 1'b1;
                                OP_WRDI:  wel_q       <= 1'b0;
                                OP_READ:  is_read_q   <= 1'b1;
                                OP_WRITE: is_read_q   <= 1'b0;
                                OP_RDSR:  need_load_q <= 1'b1;
                                default:  ;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        if (byte_done) begin
                            if (!addr_second_q) begin
                                addr_hi_q     <= byte_val[HI_W-1:0];
                                addr_second_q <= 1'b1;
                            end else begin
                                ptr_q       <= {addr_hi_q, byte_val};
                                need_load_q <= is_read_q;
                            end
                        end
                    end
                    ST_READ, ST_RDSR: if (byte_done) need_load_q <= 1'b1;
                    ST_WRITE: begin
                        if (byte_done) begin
                            wr_stb_q  <= 1'b1;
                            wr_addr_q <= ptr_q;
                            wr_data_q <= byte_val;
                            ptr_q     <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + P_ONE};
                            wr_any_q  <= 1'b1;
                        end
                    end
                    ST_WRSR: begin
                        if (byte_done) begin
                            usr_q <= byte_val[7:2];
                            wel_q <= 1'b0;
                        end
                    end
                    ST_IDLE, ST_SKIP: ;
                endcase
                if (fall && need_load_q) begin
                    need_load_q <= 1'b0;
                    out_act_q   <= 1'b1;
                    if (state_q == ST_READ) ptr_q <= ptr_q + A_ONE;
                end
            end
        end
    end

    assign so_oe     = out_act_q & hold_s;
    assign rd_addr   = ptr_q;
    assign wr_stb    = wr_stb_q;
    assign wr_addr   = wr_addr_q;
    assign wr_data   = wr_data_q;
    assign wr_commit = wr_commit_q;
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              hold_s,
    input logic              so_oe,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_stb,
    input logic              wr_commit,
    input logic              wel_q
);
    // R6
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !so_oe);

    // R7
    hold_ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> $stable(rd_addr));

    // R7
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |=> !wr_stb);

    // R9
    strobe_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> wel_q);

    // R10
    commit_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !wel_q);

    // R10
    strobe_commit_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, wr_commit}));
endmodule

bind spi_mem_front spi_mem_front_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_s     (csn_s),
    .hold_s    (hold_s),
    .so_oe     (so_oe),
    .rd_addr   (rd_addr),
    .wr_stb    (wr_stb),
    .wr_commit (wr_commit),
    .wel_q     (wel_q)
);

// File: tb/test_spi_mem_front.sv
module test_spi_mem_front;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic        so, so_oe;
    logic [11:0] rd_addr, wr_addr;
    logic [7:0]  rd_data, wr_data;
    logic        wr_stb, wr_commit, commit_busy;
    logic        busy_force = 1'b0;
    int          busy_cnt;
    int          n_stb = 0, n_commit = 0;
    int          total = 0, bad = 0;
    logic [7:0]  mem [4096];

    always #5 clk = ~clk;

    spi_mem_front i_spi_mem_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .commit_busy(commit_busy)
    );

    function automatic logic [7:0] init8(input int a);
        return 8'(a) ^ {4'(a >> 8), 4'(a >> 8)} ^ 8'h5A;
    endfunction

    assign rd_data     = mem[rd_addr];
    assign commit_busy = busy_force | (busy_cnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= init8(i);
            busy_cnt <= 0;
        end else begin
            if (wr_stb) begin
                mem[wr_addr] <= wr_data;
                n_stb <= n_stb + 1;
            end
            if (wr_commit) begin
                n_commit <= n_commit + 1;
                busy_cnt <= 600;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic r, output logic oe);
        si = b;
        repeat (HALF) @(negedge clk);
        r  = so;
        oe = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all, output logic oe_any);
        logic r, oe;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(tx[i], r, oe);
            rx[i]  = r;
            oe_all = oe_all & oe;
            oe_any = oe_any | oe;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] rx;
        logic a, b;
        spi_byte(tx, rx, a, b);
    endtask

    task automatic sel;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic desel;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        sel; send(op); desel;
    endtask

    task automatic rd_status(input logic [7:0] exp, input string req);
        logic [7:0] rx;
        logic a, b;
        sel;
        send(8'h05);
        spi_byte(8'h00, rx, a, b);
        chk(rx == exp, req, "status byte", 16'(rx), 16'(exp));
        chk(a, req, "so_oe during status", 16'(a), 16'd1);
        desel;
    endtask

    task automatic do_read(input logic [15:0] addr, input int n, input string req);
        logic [7:0] rx;
        logic a, b;
        int eff;
        sel;
        send(8'h03); send(addr[15:8]); send(addr[7:0]);
        for (int k = 0; k < n; k++) begin
            eff = (int'(addr[11:0]) + k) % 4096;
            spi_byte(8'h00, rx, a, b);
            chk(rx == mem[eff], req, "read byte", 16'(rx), 16'(mem[eff]));
            chk(a, req, "so_oe in data phase", 16'(a), 16'd1);
        end
        desel;
        chk(so_oe == 1'b0, req, "so_oe after deselect", 16'(so_oe), 16'd0);
    endtask

    task automatic t_reset;
        chk(so_oe == 1'b0, "R1", "so_oe after reset", 16'(so_oe), 16'd0);
        chk(n_stb == 0 && n_commit == 0, "R1", "no strobes after reset", 16'(n_stb + n_commit), 16'd0);
        rd_status(8'h00, "R1");
    endtask

    task automatic t_read_basic;
        logic [7:0] rx;
        logic a, b;
        sel;
        send(8'h03);
        spi_byte(8'h01, rx, a, b);
        chk(b == 1'b0, "R3", "so_oe off in address phase", 16'(b), 16'd0);
        send(8'h23);
        desel;
        do_read(16'h0123, 3, "R2");
    endtask

    task automatic t_read_page_cross;
        do_read(16'h001E, 4, "R4");
    endtask

    task automatic t_read_wrap_upper;
        do_read(16'hAFFE, 4, "R5");
        do_read(16'h0FFF, 2, "R4");
    endtask

    task automatic t_write_no_latch;
        int s0;
        s0 = n_stb;
        sel; send(8'h02); send(8'h00); send(8'h55); send(8'h99); desel;
        chk(n_stb == s0, "R9", "strobes without latch", 16'(n_stb - s0), 16'd0);
        do_read(16'h0055, 1, "R9");
    endtask

    task automatic t_latch;
        cmd1(8'h06);
        rd_status(8'h02, "R8");
        cmd1(8'h04);
        rd_status(8'h00, "R8");
    endtask

    task automatic t_write_page_wrap;
        int s0, c0;
        s0 = n_stb;
        c0 = n_commit;
        cmd1(8'h06);
        sel; send(8'h02); send(8'h00); send(8'h3E);
        send(8'h11); send(8'h22); send(8'h33);
        desel;
        chk(n_stb - s0 == 3, "R9", "strobe count", 16'(n_stb - s0), 16'd3);
        chk(n_commit - c0 == 1, "R10", "commit pulses", 16'(n_commit - c0), 16'd1);
        rd_status(8'h01, "R10");
        repeat (700) @(negedge clk);
        chk(mem[12'h03E] == 8'h11, "R9", "byte at 0x03E", 16'(mem[12'h03E]), 16'h11);
        chk(mem[12'h03F] == 8'h22, "R9", "byte at 0x03F", 16'(mem[12'h03F]), 16'h22);
        chk(mem[12'h020] == 8'h33, "R9", "page-wrapped byte at 0x020", 16'(mem[12'h020]), 16'h33);
        chk(mem[12'h040] == init8(12'h040), "R9", "0x040 untouched", 16'(mem[12'h040]), 16'(init8(12'h040)));
        do_read(16'h003E, 3, "R9");
    endtask

    task automatic t_busy;
        logic [7:0] rx;
        logic a, b;
        int s0;
        busy_force = 1'b1;
        s0 = n_stb;
        cmd1(8'h06);
        rd_status(8'h01, "R12");
        sel;
        send(8'h03); send(8'h00); send(8'h10);
        spi_byte(8'h00, rx, a, b);
        chk(b == 1'b0, "R12", "read refused while busy", 16'(b), 16'd0);
        desel;
        busy_force = 1'b0;
        rd_status(8'h00, "R12");
        chk(n_stb == s0, "R12", "no strobes while busy", 16'(n_stb - s0), 16'd0);
    endtask

    task automatic t_hold;
        logic [7:0] rx, d1;
        logic a, b, r, oe;
        sel;
        send(8'h03); send(8'h02); send(8'h1F);
        spi_byte(8'h00, rx, a, b);
        chk(rx == mem[12'h21F], "R7", "byte before hold", 16'(rx), 16'(mem[12'h21F]));
        for (int i = 7; i >= 5; i--) begin
            spi_bit(1'b0, r, oe);
            d1[i] = r;
        end
        hold_n = 1'b0;
        repeat (10) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            spi_bit(1'b1, r, oe);
            chk(oe == 1'b0, "R7", "so_oe while held", 16'(oe), 16'd0);
        end
        hold_n = 1'b1;
        repeat (10) @(negedge clk);
        for (int i = 4; i >= 0; i--) begin
            spi_bit(1'b0, r, oe);
            d1[i] = r;
        end
        chk(d1 == mem[12'h220], "R7", "byte split by hold", 16'(d1), 16'(mem[12'h220]));
        spi_byte(8'h00, rx, a, b);
        chk(rx == mem[12'h221], "R7", "byte after hold", 16'(rx), 16'(mem[12'h221]));
        desel;
    endtask

    task automatic t_unknown;
        logic [7:0] rx;
        logic a, b, any;
        int s0;
        s0 = n_stb;
        any = 1'b0;
        cmd1(8'h06);
        sel;
        send(8'hFF);
        spi_byte(8'h02, rx, a, b); any |= b;
        spi_byte(8'h00, rx, a, b); any |= b;
        spi_byte(8'h10, rx, a, b); any |= b;
        spi_byte(8'hAB, rx, a, b); any |= b;
        desel;
        chk(any == 1'b0, "R13", "so_oe after unknown opcode", 16'(any), 16'd0);
        chk(n_stb == s0, "R13", "no strobes after unknown opcode", 16'(n_stb - s0), 16'd0);
        cmd1(8'h04);
    endtask

    task automatic t_abort;
        sel; send(8'h03); send(8'h04); desel;
        chk(so_oe == 1'b0, "R6", "so_oe after abort", 16'(so_oe), 16'd0);
        do_read(16'h0456, 2, "R6");
    endtask

    task automatic t_wrsr;
        cmd1(8'h01);
        rd_status(8'h00, "R11");
        sel; send(8'h01); send(8'hFC); desel;
        rd_status(8'h00, "R11");
        cmd1(8'h06);
        sel; send(8'h01); send(8'hA7); desel;
        rd_status(8'hA4, "R11");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_read_basic;
        t_read_page_cross;
        t_read_wrap_upper;
        t_write_no_latch;
        t_latch;
        t_write_page_wrap;
        t_busy;
        t_hold;
        t_unknown;
        t_abort;
        t_wrsr;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule